// File: doc/BRIEF.md
# Prioritized Interrupt Pending and Enable Controller

This block gathers up to 32 external interrupt lines. For each line it keeps an enable bit, a pending bit, an active bit and an 8-bit priority. Software reaches this state through a flat word-addressed register interface. Enable and pending each have two write views: one where writing 1 sets bits and one where writing 1 clears them. A separate trigger register pends a line by its number.

Every cycle the block searches the lines that are both pending and enabled and picks the one with the numerically smallest priority. It reports that winner as a vector number (line plus 16) with a valid flag. An acknowledge input moves the winner from pending to active. An end-of-service input, carrying a line number, retires the active bit of that line. A disabled line still collects pending requests, so software can poll it as a latched input.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A write of 1 to a bit at offset 0x100 enables that line, and a write of 1 at offset 0x180 disables it. Zero bits leave the enable unchanged, and both offsets read back the current enable mask.
- R2: A write of 1 at offset 0x200 pends a line, and a write of 1 at offset 0x280 un-pends it. Zero bits have no effect, and both offsets read back the current pending mask.
- R3: A pending line whose enable is clear is never reported as the winner, and its pending bit stays readable until software clears it.
- R4: The priority of line n sits in the word at offset 0x400 + 4*(n/4), in bits [8*(n%4)+7 : 8*(n%4)]. Each such word reads back what was written.
- R5: Among the lines that are pending and enabled, the smallest priority value wins. When priorities are equal, the lower line number wins.
- R6: When a winner exists, pendValid is 1 and pendVector equals the line number plus 16. With no eligible line, pendValid is 0 and pendVector is 0.
- R7: Writing a line number to bits [7:0] at offset 0xF00 pends that line. A number at or beyond the line count changes nothing.
- R8: A line is pended on a rising edge of its input. While the input stays high it does not pend again.
- R9: irqAck, sampled while pendValid is 1, clears the winner's pending bit and sets its active bit. The active mask reads at offset 0x300.
- R10: eosValid together with eosLine clears the active bit of that line.
- R11: A clear-pending write overrides a rising edge or set on the same bit in the same cycle.
- R12: Reset clears all enable, pending, active and priority state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| irqIn | input | NUM_LINES | Interrupt request inputs |
| irqAck | input | 1 | Accept the current winner |
| eosValid | input | 1 | End of service strobe |
| eosLine | input | LINE_W | Line whose service ends |
| pendValid | output | 1 | An eligible line exists |
| pendVector | output | 9 | Winner line plus 16, or 0 |

## Verification
The bench builds the block with its default of 32 lines. This puts the top line 31 (vector 47) and the last priority word at 0x41C within reach. It also makes a trigger number of 40 a genuine out-of-range case. With a full word of lines, the set and clear views can be exercised on multi-bit masks, and priority ties can be set up between lines that sit in different priority words.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 12;
  localparam int PRIO_W   = 8;
  localparam int VEC_W    = 9;
  localparam int VEC_BASE = 16;

  localparam logic [ADDR_W-1:0] OFS_EN_SET   = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR   = 12'h180;
  localparam logic [ADDR_W-1:0] OFS_PEND_SET = 12'h200;
  localparam logic [ADDR_W-1:0] OFS_PEND_CLR = 12'h280;
  localparam logic [ADDR_W-1:0] OFS_ACTIVE   = 12'h300;
  localparam logic [ADDR_W-1:0] OFS_PRIO     = 12'h400;
  localparam logic [ADDR_W-1:0] OFS_TRIG     = 12'hF00;

  // strobes from the control module to the state datapath
  typedef struct packed {
    logic [REG_W-1:0] enSet;
    logic [REG_W-1:0] enClr;
    logic [REG_W-1:0] pendSet;
    logic [REG_W-1:0] pendClr;
    logic [REG_W-1:0] trig;
    logic [REG_W-1:0] eosClr;
    logic             prioWr;
    logic [7:0]       prioWord;
    logic             ack;
  } ctrl_stb_t;
endpackage

// File: rtl/irq_ctrl_regbank.sv
module irq_ctrl_regbank
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_LINES = 32,
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int PRIO_WORDS = (NUM_LINES + 3) / 4
) (
  input  logic                        regWrEn,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [REG_W-1:0]            regWrData,
  output logic [REG_W-1:0]            regRdData,
  input  logic                        irqAck,
  input  logic                        eosValid,
  input  logic [LINE_W-1:0]           eosLine,
  input  logic                        winValid,
  input  logic [NUM_LINES-1:0]        enQ,
  input  logic [NUM_LINES-1:0]        pendQ,
  input  logic [NUM_LINES-1:0]        actQ,
  input  logic [NUM_LINES*PRIO_W-1:0] prioFlat,
  output ctrl_stb_t                   stb
);
  localparam logic [7:0] LINES8 = 8'(NUM_LINES);
  localparam logic [ADDR_W-3:0] PW = (ADDR_W-2)'(PRIO_WORDS);

  logic [ADDR_W-1:0] prioOfs;
  logic              isPrio;
  logic [REG_W-1:0]  enW, pendW, actW, prioRd;

  assign prioOfs = regAddr - OFS_PRIO;
  assign isPrio  = (regAddr[1:0] == 2'b00) && (regAddr >= OFS_PRIO) &&
                   (prioOfs[ADDR_W-1:2] < PW);

  always_comb begin
    stb          = '0;
    stb.enSet    = (regWrEn && regAddr == OFS_EN_SET)   ? regWrData : '0;
    stb.enClr    = (regWrEn && regAddr == OFS_EN_CLR)   ? regWrData : '0;
    stb.pendSet  = (regWrEn && regAddr == OFS_PEND_SET) ? regWrData : '0;
    stb.pendClr  = (regWrEn && regAddr == OFS_PEND_CLR) ? regWrData : '0;
    if (regWrEn && regAddr == OFS_TRIG && regWrData[7:0] < LINES8)
      stb.trig = REG_W'(1) << regWrData[7:0];
    if (eosValid)
      stb.eosClr = REG_W'(1) << eosLine;
    stb.prioWr   = regWrEn && isPrio;
    stb.prioWord = 8'(prioOfs[ADDR_W-1:2]);
    stb.ack      = irqAck && winValid;
  end

  always_comb begin
    enW   = '0;
    pendW = '0;
    actW  = '0;
    enW[NUM_LINES-1:0]   = enQ;
    pendW[NUM_LINES-1:0] = pendQ;
    actW[NUM_LINES-1:0]  = actQ;
    prioRd = '0;
    for (int k = 0; k < 4; k++) begin
      int lineIdx;
      lineIdx = int'(prioOfs[ADDR_W-1:2]) * 4 + k;
      if (lineIdx < NUM_LINES)
        prioRd[8*k +: 8] = prioFlat[PRIO_W*lineIdx +: PRIO_W];
    end
  end

  always_comb begin
    if (regAddr == OFS_EN_SET || regAddr == OFS_EN_CLR)
      regRdData = enW;
    else if (regAddr == OFS_PEND_SET || regAddr == OFS_PEND_CLR)
      regRdData = pendW;
    else if (regAddr == OFS_ACTIVE)
      regRdData = actW;
    else if (isPrio)
      regRdData = prioRd;
    else
      regRdData = '0;
  end
endmodule

// File: rtl/irq_ctrl_state.sv
module irq_ctrl_state
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_LINES = 32,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrl_stb_t                   stb,
  input  logic [REG_W-1:0]            wrData,
  input  logic [NUM_LINES-1:0]        irqIn,
  input  logic [LINE_W-1:0]           winIdx,
  output logic [NUM_LINES-1:0]        enQ,
  output logic [NUM_LINES-1:0]        pendQ,
  output logic [NUM_LINES-1:0]        actQ,
  output logic [NUM_LINES*PRIO_W-1:0] prioFlat
);
  logic [NUM_LINES-1:0] irqPrev, rise, ackMask, setAll, clrAll;
  logic [PRIO_W-1:0]    prioQ [NUM_LINES];

  assign rise    = irqIn & ~irqPrev;
  assign ackMask = stb.ack ? (NUM_LINES'(1) << winIdx) : '0;
  assign setAll  = stb.pendSet[NUM_LINES-1:0] | stb.trig[NUM_LINES-1:0] | rise;
  assign clrAll  = stb.pendClr[NUM_LINES-1:0] | ackMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPrev <= '0;
      enQ     <= '0;
      pendQ   <= '0;
      actQ    <= '0;
    end else begin
      irqPrev <= irqIn;
      enQ     <= (enQ | stb.enSet[NUM_LINES-1:0]) & ~stb.enClr[NUM_LINES-1:0];
      pendQ   <= (pendQ | setAll) & ~clrAll;
      actQ    <= (actQ & ~stb.eosClr[NUM_LINES-1:0]) | ackMask;
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : gPrio
    always_ff @(posedge clk) begin
      if (!rstN)
        prioQ[g] <= '0;
      else if (stb.prioWr && stb.prioWord == 8'(g / 4))
        prioQ[g] <= wrData[8*(g%4) +: PRIO_W];
    end
    assign prioFlat[PRIO_W*g +: PRIO_W] = prioQ[g];
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pendClr != '0) |=> ((pendQ & $past(stb.pendClr[NUM_LINES-1:0])) == '0)); // R11
  AST_ENA_SET: assert property (@(posedge clk) disable iff (!rstN)
    (stb.enSet != '0 && stb.enClr == '0) |=>
      ((enQ & $past(stb.enSet[NUM_LINES-1:0])) == $past(stb.enSet[NUM_LINES-1:0]))); // R1
  AST_ENA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enQ) & ~enQ & ~$past(stb.enClr[NUM_LINES-1:0])) == '0); // R1
  AST_ACK_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    stb.ack |=> (actQ[$past(winIdx)] && !pendQ[$past(winIdx)])); // R9
  AST_EOS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.eosClr != '0 && !stb.ack) |=> ((actQ & $past(stb.eosClr[NUM_LINES-1:0])) == '0)); // R10
endmodule

// File: rtl/irq_ctrl_pick.sv
module irq_ctrl_pick
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_LINES = 32,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_LINES-1:0]        enQ,
  input  logic [NUM_LINES-1:0]        pendQ,
  input  logic [NUM_LINES*PRIO_W-1:0] prioFlat,
  output logic                        winValid,
  output logic [LINE_W-1:0]           winIdx,
  output logic [VEC_W-1:0]            pendVector
);
  logic [NUM_LINES-1:0] eligible;
  logic [PRIO_W-1:0]    bestPri;

  assign eligible = enQ & pendQ;

  // ascending scan with strict compare keeps the lower line on ties
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    bestPri  = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (eligible[i] && (!winValid || prioFlat[PRIO_W*i +: PRIO_W] < bestPri)) begin
        winValid = 1'b1;
        winIdx   = LINE_W'(i);
        bestPri  = prioFlat[PRIO_W*i +: PRIO_W];
      end
    end
  end

  assign pendVector = winValid ? (VEC_W'(winIdx) + VEC_W'(VEC_BASE)) : '0;

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (pendVector >= VEC_W'(VEC_BASE) &&
                  pendVector < VEC_W'(VEC_BASE + NUM_LINES))); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !winValid |-> (pendVector == '0)); // R6
  AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (enQ[winIdx] && pendQ[winIdx])); // R3
  AST_ANY_FOUND: assert property (@(posedge clk) disable iff (!rstN)
    (eligible != '0) |-> winValid); // R5
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_LINES = 32,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 irqAck,
  input  logic                 eosValid,
  input  logic [LINE_W-1:0]    eosLine,
  output logic                 pendValid,
  output logic [VEC_W-1:0]     pendVector
);
  ctrl_stb_t                   stb;
  logic [NUM_LINES-1:0]        enQ, pendQ, actQ;
  logic [NUM_LINES*PRIO_W-1:0] prioFlat;
  logic [LINE_W-1:0]           winIdx;

  irq_ctrl_regbank #(.NUM_LINES(NUM_LINES)) ctrl_i (
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqAck(irqAck), .eosValid(eosValid),
    .eosLine(eosLine), .winValid(pendValid), .enQ(enQ), .pendQ(pendQ),
    .actQ(actQ), .prioFlat(prioFlat), .stb(stb)
  );

  irq_ctrl_state #(.NUM_LINES(NUM_LINES)) state_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWrData), .irqIn(irqIn),
    .winIdx(winIdx), .enQ(enQ), .pendQ(pendQ), .actQ(actQ), .prioFlat(prioFlat)
  );

  irq_ctrl_pick #(.NUM_LINES(NUM_LINES)) pick_i (
    .clk(clk), .rstN(rstN), .enQ(enQ), .pendQ(pendQ), .prioFlat(prioFlat),
    .winValid(pendValid), .winIdx(winIdx), .pendVector(pendVector)
  );
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  localparam logic [11:0] A_ENS = 12'h100, A_ENC = 12'h180, A_PS = 12'h200,
                          A_PC = 12'h280, A_ACT = 12'h300, A_PRI = 12'h400,
                          A_TRG = 12'hF00;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] irqIn = '0;
  logic        irqAck = 1'b0;
  logic        eosValid = 1'b0;
  logic [4:0]  eosLine = '0;
  logic        pendValid;
  logic [8:0]  pendVector;
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqIn(irqIn),
    .irqAck(irqAck), .eosValid(eosValid), .eosLine(eosLine),
    .pendValid(pendValid), .pendVector(pendVector)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic cleanAll();
    wr(A_ENC, '1);
    wr(A_PC, '1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_ENS, v);  check("R12 enable after reset", v, 0);
    rd(A_PS, v);   check("R12 pending after reset", v, 0);
    rd(A_ACT, v);  check("R12 active after reset", v, 0);
    rd(A_PRI + 12'h1C, v); check("R12 priority after reset", v, 0);
    check("R6 idle valid", {31'b0, pendValid}, 0);
    check("R6 idle vector", {23'b0, pendVector}, 0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(A_ENS, 32'h0000_00F0);
    rd(A_ENS, v); check("R1 set view", v, 32'hF0);
    rd(A_ENC, v); check("R1 clear view reads enable", v, 32'hF0);
    wr(A_ENS, 0);
    rd(A_ENS, v); check("R1 zero set no effect", v, 32'hF0);
    wr(A_ENC, 32'h30);
    rd(A_ENS, v); check("R1 clear bits", v, 32'hC0);
    wr(A_ENC, 0);
    rd(A_ENC, v); check("R1 zero clear no effect", v, 32'hC0);
    cleanAll();
  endtask

  task automatic t_pending();
    logic [31:0] v;
    wr(A_PS, 32'h8000_0005);
    rd(A_PC, v); check("R2 set pend", v, 32'h8000_0005);
    wr(A_PS, 0);
    wr(A_PC, 32'h1);
    rd(A_PS, v); check("R2 clear pend", v, 32'h8000_0004);
    check("R3 disabled pend not reported", {31'b0, pendValid}, 0);
    cleanAll();
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    @(negedge clk); irqIn[3] = 1'b1;
    @(negedge clk); irqIn[3] = 1'b0;
    rd(A_PS, v); check("R3 disabled line latches", v, 32'h8);
    check("R3 disabled line no winner", {31'b0, pendValid}, 0);
    wr(A_PC, 32'h8);
    rd(A_PS, v); check("R3 polled bit cleared", v, 0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(A_ENS, 32'h20);
    @(negedge clk); irqIn[5] = 1'b1;
    @(negedge clk);
    rd(A_PS, v); check("R8 rising edge pends", v, 32'h20);
    check("R6 vector line5", {23'b0, pendVector}, 21);
    wr(A_PC, 32'h20);
    repeat (3) @(negedge clk);
    rd(A_PS, v); check("R8 held high no repend", v, 0);
    irqIn[5] = 1'b0;
    cleanAll();
  endtask

  task automatic t_prio();
    logic [31:0] v;
    wr(A_ENS, 32'h42); wr(A_PS, 32'h42);
    wr(A_PRI, 32'h4030_2010);
    wr(A_PRI + 12'h4, 32'h0010_0000);
    rd(A_PRI, v); check("R4 word0 readback", v, 32'h4030_2010);
    rd(A_PRI + 12'h4, v); check("R4 word1 readback", v, 32'h0010_0000);
    check("R5 lower value wins", {23'b0, pendVector}, 22);
    wr(A_PRI + 12'h4, 32'h0020_0000);
    check("R5 tie lower line wins", {23'b0, pendVector}, 17);
    wr(A_PRI + 12'h1C, 32'h0500_0000);
    wr(A_ENS, 32'h8000_0000); wr(A_PS, 32'h8000_0000);
    check("R4 line31 top byte", {23'b0, pendVector}, 47);
    check("R6 valid with winner", {31'b0, pendValid}, 1);
    cleanAll();
    check("R6 valid cleared", {31'b0, pendValid}, 0);
  endtask

  task automatic t_trig();
    logic [31:0] v;
    wr(A_TRG, 32'd9);
    rd(A_PS, v); check("R7 trigger line9", v, 32'h200);
    wr(A_TRG, 32'd40);
    rd(A_PS, v); check("R7 out of range ignored", v, 32'h200);
    wr(A_TRG, 32'd31);
    rd(A_PS, v); check("R7 trigger line31", v, 32'h8000_0200);
    cleanAll();
  endtask

  task automatic t_ack();
    logic [31:0] v;
    wr(A_ENS, 32'h4); wr(A_TRG, 32'd2);
    check("R6 vector line2", {23'b0, pendVector}, 18);
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
    rd(A_PS, v); check("R9 ack clears pending", v, 0);
    rd(A_ACT, v); check("R9 ack sets active", v, 32'h4);
    check("R9 no winner after ack", {31'b0, pendValid}, 0);
    @(negedge clk); eosValid = 1'b1; eosLine = 5'd2;
    @(negedge clk); eosValid = 1'b0;
    rd(A_ACT, v); check("R10 end of service clears active", v, 0);
    cleanAll();
  endtask

  task automatic t_collide();
    logic [31:0] v;
    @(negedge clk);
    regWrEn = 1'b1; regAddr = A_PC; regWrData = 32'h80; irqIn[7] = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    rd(A_PS, v); check("R11 clear beats edge", v, 0);
    irqIn[7] = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_pending();
    t_disabled();
    t_edge();
    t_prio();
    t_trig();
    t_ack();
    t_collide();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule